// File: doc/BRIEF.md
# Endpoint ready-flag and interrupt controller

This block keeps one ready flag per endpoint buffer of a small USB device function and turns those flags into one maskable interrupt line for a local microcontroller. Receive flags and the setup flag are raised by hardware when a valid packet has been captured, and they hold the buffer locked until firmware releases it. Transmit flags are raised by firmware once a buffer is loaded, and they fall when the host acknowledges the packet. A free transmit buffer raises an interrupt, so the interrupt always means that firmware has work to do.

Firmware reaches the block through a byte-wide register port that has a single-cycle write strobe and a read strobe. Read data arrives one cycle after the strobe. The same port gives access to the interrupt-enable mask, the pin polarity, and a device-state register. The device-state register holds the suspend flag and the remote-wakeup request, and it also carries the bit that clears a latched bus-reset event. The interrupt pin is registered, and its active level can be programmed.

Top module: `ep_prdy_irq_ctrl`

## Requirements
- R1: After a synchronous reset: the flag register reads 0x00, the enable register reads 0x01 (only setup enabled), the polarity and device-state registers read 0x00, the status register reads 0x00, and intr is low. The register addresses are 0 for flags, 1 for enable, 2 for polarity, 3 for device state and 4 for status (read only).
- R2: A pulse on rx_pkt_ok[i] sets receive flag i, which is bit 1+i of the flag register. That flag drives rx_lock[i] from the next cycle, and it holds until firmware clears it.
- R3: Writing the flag register with bit 1+i at 1 clears receive flag i. Writing 0 to any bit of the flag register changes no flag.
- R4: When a hardware set and a firmware clear of the setup flag or a receive flag fall in the same cycle, the flag ends up set.
- R5: Writing 1 to bit 3+j of the flag register sets transmit flag j, and tx_pending[j] goes high. A pulse on tx_ack[j] clears the flag.
- R6: When a firmware set and tx_ack[j] fall in the same cycle, transmit flag j ends up set.
- R7: Each status bit is its source ANDed with the enable bit at the same position. The sources are: bit 0 the setup flag, bits 1-2 the receive flags, bits 3-4 the inverted transmit flags, bit 5 the latched bus reset, and bit 6 the suspend flag.
- R8: A bus_reset pulse latches the bus-reset status only while enable bit 5 is 1. The latch clears only when device-state bit 2 is written as 1, and bit 2 always reads as 0.
- R9: intr equals the OR of all status bits, registered for one cycle, XORed with polarity bit 0. The pin is active high when that bit is 0 and active low when it is 1.
- R10: Device-state bit 0 sets on suspend_enter and clears on resume. Bit 1, the remote-wakeup request, is written by firmware and clears on resume.
- R11: A setup_ok pulse sets the setup flag (flag bit 0), which drives setup_lock. Writing 1 to flag bit 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |
| setup_ok | input | 1 | Valid setup packet captured |
| rx_pkt_ok | input | NUM_RX | Valid OUT packet received, per receive endpoint |
| tx_ack | input | NUM_TX | Host ACK for an IN packet, per transmit endpoint |
| bus_reset | input | 1 | USB bus reset detected |
| suspend_enter | input | 1 | Bus entered suspend |
| resume | input | 1 | Resume signalling seen |
| setup_lock | output | 1 | Setup buffer locked |
| rx_lock | output | NUM_RX | Receive buffer locked, per endpoint |
| tx_pending | output | NUM_TX | Transmit packet armed, per endpoint |
| intr | output | 1 | Interrupt pin, programmable polarity |

## Verification
A hardware event and a firmware write can reach the same flag in the same clock cycle: a received packet can meet a release write, and an ACK can meet a re-arm write. The bench provokes both by driving the event input and the write strobe on the same edge. It then judges the result from the flag register read back and from the rx_lock, setup_lock and tx_pending pins, and expects the flag to be set in each case. Sequences of ordinary events and writes are checked against a vector table of expected flag and status bytes.

// File: rtl/prdy_pkg.sv
package prdy_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_FLAGS = 3'd0,
    A_IEN   = 3'd1,
    A_POL   = 3'd2,
    A_DEV   = 3'd3,
    A_STAT  = 3'd4
  } reg_addr_e;

  localparam int DEV_SUSP   = 0;
  localparam int DEV_RWK    = 1;
  localparam int DEV_RSTCLR = 2;
endpackage

// File: rtl/prdy_flag_bank.sv
module prdy_flag_bank #(
  parameter int N       = 2,
  parameter bit SW_SETS = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_ev,
  input  logic         sw_wr,
  input  logic [N-1:0] sw_bits,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic r;
    if (SW_SETS) begin : g_tx
      // firmware arms, host ACK releases; arming wins a tie
      always_ff @(posedge clk) begin
        if (rst)                       r <= 1'b0;
        else if (sw_wr && sw_bits[i])  r <= 1'b1;
        else if (hw_ev[i])             r <= 1'b0;
      end
    end else begin : g_rx
      // hardware captures, firmware releases; capture wins a tie
      always_ff @(posedge clk) begin
        if (rst)                       r <= 1'b0;
        else if (hw_ev[i])             r <= 1'b1;
        else if (sw_wr && sw_bits[i])  r <= 1'b0;
      end
    end
    assign q[i] = r;
  end
endmodule

// File: rtl/prdy_devstate.sv
module prdy_devstate
  import prdy_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              suspend_enter,
  input  logic              resume,
  input  logic              bus_reset,
  input  logic              brst_en,
  output logic              suspended,
  output logic              rwake,
  output logic              busrst_stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      suspended   <= 1'b0;
      rwake       <= 1'b0;
      busrst_stat <= 1'b0;
    end else begin
      if (suspend_enter)   suspended <= 1'b1;
      else if (resume)     suspended <= 1'b0;

      if (resume)          rwake <= 1'b0;
      else if (wr)         rwake <= wr_data[DEV_RWK];

      if (bus_reset && brst_en)            busrst_stat <= 1'b1;
      else if (wr && wr_data[DEV_RSTCLR])  busrst_stat <= 1'b0;
    end
  end
endmodule

// File: rtl/prdy_irq.sv
module prdy_irq #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic [W-1:0] ien,
  input  logic         pol,
  output logic [W-1:0] status,
  output logic         intr
);
  assign status = src & ien;

  always_ff @(posedge clk) begin
    if (rst) intr <= 1'b0;
    else     intr <= (|status) ^ pol;
  end
endmodule

// File: rtl/ep_prdy_irq_ctrl.sv
module ep_prdy_irq_ctrl
  import prdy_pkg::*;
#(
  parameter int NUM_RX = 2,
  parameter int NUM_TX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              setup_ok,
  input  logic [NUM_RX-1:0] rx_pkt_ok,
  input  logic [NUM_TX-1:0] tx_ack,
  input  logic              bus_reset,
  input  logic              suspend_enter,
  input  logic              resume,
  output logic              setup_lock,
  output logic [NUM_RX-1:0] rx_lock,
  output logic [NUM_TX-1:0] tx_pending,
  output logic              intr
);
  localparam int RX_LO    = 1;
  localparam int TX_LO    = RX_LO + NUM_RX;
  localparam int BRST_BIT = TX_LO + NUM_TX;
  localparam int SUSP_BIT = BRST_BIT + 1;
  localparam int NBITS    = SUSP_BIT + 1;
  localparam int NFLAGS   = BRST_BIT;

  logic wr_flags, wr_ien, wr_pol, wr_dev;
  assign wr_flags = wr_en && (wr_addr == A_FLAGS);
  assign wr_ien   = wr_en && (wr_addr == A_IEN);
  assign wr_pol   = wr_en && (wr_addr == A_POL);
  assign wr_dev   = wr_en && (wr_addr == A_DEV);

  logic [NBITS-1:0] wdat;
  assign wdat = NBITS'(wr_data);

  logic [0:0] setup_q;
  prdy_flag_bank #(.N(1), .SW_SETS(1'b0)) setup_bank_i (
    .clk(clk), .rst(rst), .hw_ev(setup_ok), .sw_wr(wr_flags),
    .sw_bits(wdat[0]), .q(setup_q)
  );

  prdy_flag_bank #(.N(NUM_RX), .SW_SETS(1'b0)) rx_bank_i (
    .clk(clk), .rst(rst), .hw_ev(rx_pkt_ok), .sw_wr(wr_flags),
    .sw_bits(wdat[TX_LO-1:RX_LO]), .q(rx_lock)
  );

  prdy_flag_bank #(.N(NUM_TX), .SW_SETS(1'b1)) tx_bank_i (
    .clk(clk), .rst(rst), .hw_ev(tx_ack), .sw_wr(wr_flags),
    .sw_bits(wdat[BRST_BIT-1:TX_LO]), .q(tx_pending)
  );

  assign setup_lock = setup_q[0];

  logic [NBITS-1:0] ien_q;
  logic             pol_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= NBITS'(1);
      pol_q <= 1'b0;
    end else begin
      if (wr_ien) ien_q <= wdat;
      if (wr_pol) pol_q <= wr_data[0];
    end
  end

  logic suspended, rwake, busrst_stat;
  prdy_devstate dev_i (
    .clk(clk), .rst(rst), .wr(wr_dev), .wr_data(wr_data),
    .suspend_enter(suspend_enter), .resume(resume),
    .bus_reset(bus_reset), .brst_en(ien_q[BRST_BIT]),
    .suspended(suspended), .rwake(rwake), .busrst_stat(busrst_stat)
  );

  logic [NBITS-1:0] int_src, int_status;
  assign int_src = {suspended, busrst_stat, ~tx_pending, rx_lock, setup_q};

  prdy_irq #(.W(NBITS)) irq_i (
    .clk(clk), .rst(rst), .src(int_src), .ien(ien_q), .pol(pol_q),
    .status(int_status), .intr(intr)
  );

  logic [NFLAGS-1:0] flags_all;
  assign flags_all = {tx_pending, rx_lock, setup_q};

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    case (rd_addr)
      A_FLAGS: rd_mux = DATA_W'(flags_all);
      A_IEN:   rd_mux = DATA_W'(ien_q);
      A_POL:   rd_mux = DATA_W'(pol_q);
      A_DEV:   rd_mux = DATA_W'({rwake, suspended});
      A_STAT:  rd_mux = DATA_W'(int_status);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/prdy_chk.sv
module prdy_chk
  import prdy_pkg::*;
#(
  parameter int NUM_RX = 2,
  parameter int NUM_TX = 2,
  parameter int NBITS  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              setup_ok,
  input logic              setup_lock,
  input logic [NUM_RX-1:0] rx_pkt_ok,
  input logic [NUM_RX-1:0] rx_lock,
  input logic [NUM_TX-1:0] tx_ack,
  input logic [NUM_TX-1:0] tx_pending,
  input logic              intr,
  input logic [NBITS-1:0]  int_status,
  input logic              pol_q,
  input logic              busrst_stat
);
  logic wf;
  assign wf = wr_en && (wr_addr == A_FLAGS);

  // R11: setup capture shows on the lock pin next cycle
  p_setup_set_r11: assert property (@(posedge clk) disable iff (rst)
    setup_ok |=> setup_lock);

  for (genvar i = 0; i < NUM_RX; i++) begin : g_rx
    // R2 / R4: capture always lands, even against a release write
    p_rx_set_r2: assert property (@(posedge clk) disable iff (rst)
      rx_pkt_ok[i] |=> rx_lock[i]);
    // R3: only a 1 written at the flag's position releases it
    p_rx_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (rx_lock[i] && !(wf && wr_data[1+i])) |=> rx_lock[i]);
  end

  for (genvar j = 0; j < NUM_TX; j++) begin : g_tx
    // R6: arming wins against ACK
    p_tx_set_r6: assert property (@(posedge clk) disable iff (rst)
      (wf && wr_data[1+NUM_RX+j]) |=> tx_pending[j]);
    // R5: ACK releases an unarmed slot
    p_tx_ack_r5: assert property (@(posedge clk) disable iff (rst)
      (tx_ack[j] && !(wf && wr_data[1+NUM_RX+j])) |=> !tx_pending[j]);
  end

  // R9: pin follows status OR with one register and polarity
  p_intr_pin_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (intr == ($past(|int_status) ^ $past(pol_q))));

  // R8: latched bus reset survives until the clear bit is written
  p_brst_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busrst_stat && !(wr_en && wr_addr == A_DEV && wr_data[DEV_RSTCLR]))
      |=> busrst_stat);
endmodule

bind ep_prdy_irq_ctrl prdy_chk #(
  .NUM_RX(NUM_RX), .NUM_TX(NUM_TX), .NBITS(NBITS)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .setup_ok(setup_ok), .setup_lock(setup_lock),
  .rx_pkt_ok(rx_pkt_ok), .rx_lock(rx_lock),
  .tx_ack(tx_ack), .tx_pending(tx_pending),
  .intr(intr), .int_status(int_status), .pol_q(pol_q),
  .busrst_stat(busrst_stat)
);

// File: tb/ep_prdy_irq_ctrl_tb_top.sv
module ep_prdy_irq_ctrl_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [7:0] ev = '0;   // 0 setup, 2:1 rx, 4:3 tx ack, 5 bus reset, 6 suspend, 7 resume
  logic       setup_lock, intr;
  logic [1:0] rx_lock, tx_pending;

  ep_prdy_irq_ctrl dut_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .setup_ok(ev[0]), .rx_pkt_ok(ev[2:1]), .tx_ack(ev[4:3]),
    .bus_reset(ev[5]), .suspend_enter(ev[6]), .resume(ev[7]),
    .setup_lock(setup_lock), .rx_lock(rx_lock), .tx_pending(tx_pending),
    .intr(intr)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic w, logic [2:0] a, logic [7:0] d, logic [7:0] e);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; ev = e;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; ev = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  // {wr, addr, data, events, expected flags, expected status}
  localparam logic [35:0] VEC [0:15] = '{
    {1'b1, 3'd1, 8'h7F, 8'h00, 8'h00, 8'h18},
    {1'b0, 3'd0, 8'h00, 8'h01, 8'h01, 8'h19},
    {1'b0, 3'd0, 8'h00, 8'h02, 8'h03, 8'h1B},
    {1'b1, 3'd0, 8'h00, 8'h00, 8'h03, 8'h1B},
    {1'b1, 3'd0, 8'h02, 8'h00, 8'h01, 8'h19},
    {1'b1, 3'd0, 8'h08, 8'h00, 8'h09, 8'h11},
    {1'b0, 3'd0, 8'h00, 8'h08, 8'h01, 8'h19},
    {1'b0, 3'd0, 8'h00, 8'h20, 8'h01, 8'h39},
    {1'b1, 3'd3, 8'h00, 8'h00, 8'h01, 8'h39},
    {1'b1, 3'd3, 8'h04, 8'h00, 8'h01, 8'h19},
    {1'b0, 3'd0, 8'h00, 8'h40, 8'h01, 8'h59},
    {1'b0, 3'd0, 8'h00, 8'h80, 8'h01, 8'h19},
    {1'b1, 3'd0, 8'h01, 8'h00, 8'h00, 8'h18},
    {1'b1, 3'd1, 8'h00, 8'h00, 8'h00, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'h20, 8'h00, 8'h00},
    {1'b1, 3'd1, 8'h20, 8'h00, 8'h00, 8'h00}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(3'd0, v); chk("R1 flags", v, 8'h00);
    rd(3'd1, v); chk("R1 enable", v, 8'h01);
    rd(3'd2, v); chk("R1 polarity", v, 8'h00);
    rd(3'd3, v); chk("R1 devstate", v, 8'h00);
    rd(3'd4, v); chk("R1 status", v, 8'h00);
    chk("R1 intr", {7'd0, intr}, 8'h00);

    // R2 R3 R5 R7 R8 R10 R11 vector walk
    for (int k = 0; k < 16; k++) begin
      step(VEC[k][35], VEC[k][34:32], VEC[k][31:24], VEC[k][23:16]);
      rd(3'd0, v); chk($sformatf("R2/R3/R5/R11 vec%0d flags", k), v, VEC[k][15:8]);
      rd(3'd4, v); chk($sformatf("R7/R8/R10 vec%0d status", k), v, VEC[k][7:0]);
      chk($sformatf("R9 vec%0d intr", k), {7'd0, intr}, {7'd0, VEC[k][7:0] != 8'h00});
    end

    step(1'b1, 3'd1, 8'h7F, 8'h00);
    // R4 capture against release, same cycle
    step(1'b0, 3'd0, 8'h00, 8'h02);
    step(1'b1, 3'd0, 8'h03, 8'h03);
    rd(3'd0, v); chk("R4 flags after tie", v, 8'h03);
    chk("R4 rx_lock", {6'd0, rx_lock}, 8'h01);
    chk("R4 setup_lock", {7'd0, setup_lock}, 8'h01);

    // R6 arm against ACK, same cycle
    step(1'b1, 3'd0, 8'h10, 8'h10);
    chk("R6 tx_pending", {6'd0, tx_pending}, 8'h02);
    rd(3'd0, v); chk("R6 flags", v, 8'h13);

    // R9 polarity (status 0x0B is nonzero)
    chk("R9 intr active high", {7'd0, intr}, 8'h01);
    step(1'b1, 3'd2, 8'h01, 8'h00);
    step(1'b0, 3'd0, 8'h00, 8'h00);
    chk("R9 intr active low", {7'd0, intr}, 8'h00);
    step(1'b1, 3'd2, 8'h00, 8'h00);
    step(1'b0, 3'd0, 8'h00, 8'h00);
    chk("R9 intr restored", {7'd0, intr}, 8'h01);

    // R10 / R8 device state
    step(1'b1, 3'd3, 8'h06, 8'h00);
    rd(3'd3, v); chk("R10 wakeup set, R8 clear bit reads 0", v, 8'h02);
    step(1'b0, 3'd0, 8'h00, 8'h40);
    rd(3'd3, v); chk("R10 suspended", v, 8'h03);
    step(1'b0, 3'd0, 8'h00, 8'h80);
    rd(3'd3, v); chk("R10 resume clears", v, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule